// File: doc/BRIEF.md
# Programmable Serial Clock Period Generator

This block produces the serial clock of a two-wire bus master. The low phase and the high phase of each clock period are set separately. Each is an 8-bit count of internal oscillator periods: one period of `clk`, nominally 30 ns. The register block supplies the two counts and a 2-bit speed mode. A count below the legal minimum for the selected mode is raised to that minimum. The block drives an open-drain pull-down enable for the SCL line. It reads the real line level back, so a slave that holds SCL low lengthens the high phase instead of cutting it short. A one-cycle strobe marks every phase change for the bus engine.

The control is a four-state machine:
- `ST_IDLE`: line released, counter cleared.
- `ST_DRIVE_LOW`: the block pulls the line low.
- `ST_AWAIT_HIGH`: the line is released and the block waits for it to read high.
- `ST_COUNT_HIGH`: the high phase is being timed.

It has these transitions:
- *start*: `ST_IDLE` to `ST_DRIVE_LOW` when enabled.
- *release*: `ST_DRIVE_LOW` to `ST_AWAIT_HIGH` when the low count expires.
- *sensed*: `ST_AWAIT_HIGH` to `ST_COUNT_HIGH` when the line reads high.
- *wrap*: `ST_COUNT_HIGH` to `ST_DRIVE_LOW` when the high count expires.
- *halt*: any state to `ST_IDLE` when the enable is low.

Counts and mode are sampled only on *start* and *wrap*.

Top module: `scl_period_gen`

## Requirements
- R1: Each low phase keeps `scl_pull_low` at 1 for exactly the effective low count of consecutive cycles.
- R2: After the line is released, counting of the high phase begins only in the cycle after `scl_sense` is sampled high. Without stretching, the line stays released for the effective high count plus one cycle.
- R3: The effective count is the minimum for the mode when the programmed count is below it. `bus_mode` is encoded 0 = standard (low 157, high 134), 1 = fast (44, 20), 2 = fast-plus (17, 9) and 3 = turbo (14, 5).
- R4: A programmed count at or above the mode minimum, up to 255, is used unchanged.
- R5: While the line is released and `scl_sense` reads low, the block stays released and its high phase does not advance, however long the line is held.
- R6: The low count, high count and mode are sampled only when a low phase starts. Changes during a running period alter neither its low nor its high length.
- R7: Sampling `enable` low makes the next cycle idle: line released, no strobe, counter cleared. A later enable begins with a full low phase.
- R8: `phase_strobe` is 1 for exactly one cycle: the first cycle of each low phase and the first cycle after each release. It is 0 at all other times.
- R9: During and straight after reset, `scl_pull_low` and `phase_strobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one period is the count unit |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the clock generator while 1 |
| bus_mode | input | 2 | Speed mode selecting the minimum counts |
| low_count | input | CNT_W | Programmed low-phase length |
| high_count | input | CNT_W | Programmed high-phase length |
| scl_sense | input | 1 | Sensed SCL line level |
| scl_pull_low | output | 1 | 1 pulls SCL low; 0 releases it |
| phase_strobe | output | 1 | One-cycle marker at each phase change |

## Verification
Some properties are checked on every cycle:
- clamped counts never fall below the mode floor, and legal counts pass through unchanged;
- the strobe never lasts two cycles and accompanies every new low phase;
- a low line holds the machine in `ST_AWAIT_HIGH`;
- a low enable forces the line released;
- the counter never wraps.

Only the bench scenarios can show the exact phase lengths, the cycle in which new counts take effect after a mid-period change, and the full-length restart after a disable. They do this by comparing against a cycle-level reference model over several modes, edge counts and a stretched high phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        BUS_STANDARD  = 2'd0,
        BUS_FAST      = 2'd1,
        BUS_FAST_PLUS = 2'd2,
        BUS_TURBO     = 2'd3
    } bus_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRIVE_LOW,
        ST_AWAIT_HIGH,
        ST_COUNT_HIGH
    } phase_state_e;

    // Minimum low-phase length per speed mode (R3)
    function automatic logic [7:0] floor_low(input logic [1:0] mode);
        unique case (bus_mode_e'(mode))
            BUS_STANDARD:  floor_low = 8'd157;
            BUS_FAST:      floor_low = 8'd44;
            BUS_FAST_PLUS: floor_low = 8'd17;
            default:       floor_low = 8'd14;
        endcase
    endfunction

    // Minimum high-phase length per speed mode (R3)
    function automatic logic [7:0] floor_high(input logic [1:0] mode);
        unique case (bus_mode_e'(mode))
            BUS_STANDARD:  floor_high = 8'd134;
            BUS_FAST:      floor_high = 8'd20;
            BUS_FAST_PLUS: floor_high = 8'd9;
            default:       floor_high = 8'd5;
        endcase
    endfunction

endpackage

// File: rtl/scl_count_clamp.sv
module scl_count_clamp
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] raw_low,
    input  logic [CNT_W-1:0] raw_high,
    output logic [CNT_W-1:0] eff_low,
    output logic [CNT_W-1:0] eff_high
);
    localparam int NPHASE = 2;

    logic [NPHASE-1:0][CNT_W-1:0] raw_v;
    logic [NPHASE-1:0][CNT_W-1:0] floor_v;
    logic [NPHASE-1:0][CNT_W-1:0] eff_v;

    assign raw_v[0]   = raw_low;
    assign raw_v[1]   = raw_high;
    assign floor_v[0] = CNT_W'(floor_low(mode));
    assign floor_v[1] = CNT_W'(floor_high(mode));

    // One comparator and mux per phase (R3, R4)
    generate
        for (genvar g = 0; g < NPHASE; g++) begin : g_phase
            assign eff_v[g] = (raw_v[g] < floor_v[g]) ? floor_v[g] : raw_v[g];
        end
    endgenerate

    assign eff_low  = eff_v[0];
    assign eff_high = eff_v[1];

endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             cnt_zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_zero = (cnt_q == '0);

    // R1: a decrement is never requested on an expired count
    p_no_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !clr) |-> !cnt_zero);

    // R7: a clear leaves the counter at zero
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_zero);

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             scl_line,
    input  logic             cnt_zero,
    input  logic [CNT_W-1:0] eff_low,
    input  logic [CNT_W-1:0] eff_high,
    output logic             cnt_clr,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_load_val,
    output logic             cnt_dec,
    output logic             scl_drive_low,
    output logic             phase_strobe
);
    phase_state_e     state_q, state_d;
    logic [CNT_W-1:0] high_len_q;
    logic             enter_low;
    logic             enter_release;

    // Next state and counter control
    always_comb begin
        state_d      = state_q;
        cnt_clr      = 1'b0;
        cnt_load     = 1'b0;
        cnt_load_val = '0;
        cnt_dec      = 1'b0;
        if (!enable) begin
            state_d = ST_IDLE;                         // halt
            cnt_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin                         // start
                    state_d      = ST_DRIVE_LOW;
                    cnt_load     = 1'b1;
                    cnt_load_val = eff_low - 1'b1;
                end
                ST_DRIVE_LOW: begin
                    if (cnt_zero) begin
                        state_d = ST_AWAIT_HIGH;       // release
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                ST_AWAIT_HIGH: begin
                    if (scl_line) begin                // sensed
                        state_d      = ST_COUNT_HIGH;
                        cnt_load     = 1'b1;
                        cnt_load_val = high_len_q - 1'b1;
                    end
                end
                ST_COUNT_HIGH: begin
                    if (cnt_zero) begin                // wrap
                        state_d      = ST_DRIVE_LOW;
                        cnt_load     = 1'b1;
                        cnt_load_val = eff_low - 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    assign enter_low     = (state_d == ST_DRIVE_LOW)  && (state_q != ST_DRIVE_LOW);
    assign enter_release = (state_d == ST_AWAIT_HIGH) && (state_q != ST_AWAIT_HIGH);

    // State register; high length captured with the low-phase start (R6)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            high_len_q <= '0;
        end else begin
            state_q <= state_d;
            if (enter_low) begin
                high_len_q <= eff_high;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_drive_low <= 1'b0;
            phase_strobe  <= 1'b0;
        end else begin
            scl_drive_low <= (state_d == ST_DRIVE_LOW);
            phase_strobe  <= enter_low || enter_release;
        end
    end

    // R8: the strobe never lasts two cycles
    p_strobe_lone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_strobe |=> !phase_strobe);

    // R8: every new low phase is marked
    p_low_marked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> phase_strobe);

    // R7: a low enable releases the line with no strobe
    p_off_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !phase_strobe && state_q == ST_IDLE));

    // R5: a line held low keeps the machine waiting, released
    p_stretch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_AWAIT_HIGH && !scl_line)
            |=> (state_q == ST_AWAIT_HIGH && !scl_drive_low));

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       bus_mode,
    input  logic [CNT_W-1:0] low_count,
    input  logic [CNT_W-1:0] high_count,
    input  logic             scl_sense,
    output logic             scl_pull_low,
    output logic             phase_strobe
);
    logic [CNT_W-1:0] eff_low;
    logic [CNT_W-1:0] eff_high;
    logic             cnt_clr;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic             cnt_dec;
    logic             cnt_zero;

    scl_count_clamp #(.CNT_W(CNT_W)) i_clamp (
        .mode     (bus_mode),
        .raw_low  (low_count),
        .raw_high (high_count),
        .eff_low  (eff_low),
        .eff_high (eff_high)
    );

    scl_phase_counter #(.CNT_W(CNT_W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .dec      (cnt_dec),
        .cnt_zero (cnt_zero)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .scl_line      (scl_sense),
        .cnt_zero      (cnt_zero),
        .eff_low       (eff_low),
        .eff_high      (eff_high),
        .cnt_clr       (cnt_clr),
        .cnt_load      (cnt_load),
        .cnt_load_val  (cnt_load_val),
        .cnt_dec       (cnt_dec),
        .scl_drive_low (scl_pull_low),
        .phase_strobe  (phase_strobe)
    );

    // R3: clamped lengths never fall below the mode floor
    p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_low >= CNT_W'(floor_low(bus_mode))) &&
        (eff_high >= CNT_W'(floor_high(bus_mode))));

    // R4: legal programmed counts pass through untouched
    p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (low_count >= CNT_W'(floor_low(bus_mode))) |-> (eff_low == low_count));

endmodule

// File: tb/test_scl_period_gen.sv
module test_scl_period_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] md = 2'd0;
    logic [7:0] lo = 8'd0;
    logic [7:0] hi = 8'd0;
    logic       stretch = 1'b0;
    logic       scl_sense;
    logic       scl_pull_low;
    logic       phase_strobe;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    string tag = "R9";

    // Reference model state: 0 idle, 1 low, 2 waiting for line, 3 high
    int m_state = 0;
    int m_remain = 0;
    int m_high_len = 0;
    bit m_drive = 0;
    bit m_strobe = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Wired-AND line: the block or a stretching slave can hold it low
    assign scl_sense = !(scl_pull_low || stretch);

    scl_period_gen i_scl_period_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (en),
        .bus_mode     (md),
        .low_count    (lo),
        .high_count   (hi),
        .scl_sense    (scl_sense),
        .scl_pull_low (scl_pull_low),
        .phase_strobe (phase_strobe)
    );

    function automatic int min_of(input int mode, input bit high_side);
        int t_lo[4] = '{157, 44, 17, 14};
        int t_hi[4] = '{134, 20, 9, 5};
        return high_side ? t_hi[mode] : t_lo[mode];
    endfunction

    function automatic int eff(input int raw, input int mode, input bit high_side);
        return (raw < min_of(mode, high_side)) ? min_of(mode, high_side) : raw;
    endfunction

    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            begin
                bit line_high;
                line_high = !(m_drive || stretch);
                m_strobe = 0;
                if (!rst_n || !en) begin
                    m_state = 0; m_remain = 0; m_drive = 0;
                end else if (m_state == 0) begin
                    m_state = 1; m_remain = eff(lo, md, 0);
                    m_high_len = eff(hi, md, 1); m_drive = 1; m_strobe = 1;
                end else if (m_state == 1) begin
                    m_remain--;
                    if (m_remain == 0) begin
                        m_state = 2; m_drive = 0; m_strobe = 1;
                    end
                end else if (m_state == 2) begin
                    if (line_high) begin
                        m_state = 3; m_remain = m_high_len;
                    end
                end else begin
                    m_remain--;
                    if (m_remain == 0) begin
                        m_state = 1; m_remain = eff(lo, md, 0);
                        m_high_len = eff(hi, md, 1); m_drive = 1; m_strobe = 1;
                    end
                end
            end
            #1;
            vectors++;
            if (scl_pull_low !== m_drive) begin
                miscompares++;
                $display("FAIL %s scl_pull_low actual %b expected %b at cycle %0d",
                         tag, scl_pull_low, m_drive, cycles);
            end
            if (phase_strobe !== m_strobe) begin
                miscompares++;
                $display("FAIL %s phase_strobe actual %b expected %b at cycle %0d",
                         tag, phase_strobe, m_strobe, cycles);
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            miscompares++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R9: outputs quiet in reset and just after
        tag = "R9";
        en = 1'b1;
        run(3);
        rst_n = 1'b1;
        en = 1'b0;
        run(2);

        // R3: standard mode, counts below floor are raised to 157/134
        tag = "R3";
        en = 1'b1; md = 2'd0; lo = 8'd10; hi = 8'd10;
        run(700);

        // R4 and R6: fast mode legal counts, switched mid-period
        tag = "R6";
        md = 2'd1; lo = 8'd50; hi = 8'd30;
        run(300);

        // R4: fast-plus exactly at the floor
        tag = "R4";
        md = 2'd2; lo = 8'd17; hi = 8'd9;
        run(120);

        // R3: turbo with zero counts lands on 14/5
        tag = "R3";
        md = 2'd3; lo = 8'd0; hi = 8'd0;
        run(100);

        // R1: longest low and high phases
        tag = "R1";
        lo = 8'd255; hi = 8'd255;
        run(1100);

        // R5 and R2: slave holds the line low after release
        tag = "R5";
        lo = 8'd20; hi = 8'd8;
        run(60);
        while (m_state != 2) run(1);
        stretch = 1'b1;
        run(15);
        stretch = 1'b0;
        tag = "R2";
        run(80);

        // R6: new counts and mode written during a low phase
        tag = "R6";
        while (m_state != 1) run(1);
        run(3);
        md = 2'd1; lo = 8'd60; hi = 8'd40;
        run(250);

        // R7: disable during the high phase, then restart
        tag = "R7";
        md = 2'd2; lo = 8'd30; hi = 8'd25;
        while (m_state != 3) run(1);
        run(2);
        en = 1'b0;
        run(6);
        en = 1'b1;
        run(120);

        // R8: strobe pattern over several plain periods
        tag = "R8";
        md = 2'd3; lo = 8'd15; hi = 8'd6;
        run(150);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule